// File: doc/BRIEF.md
# Bus talker output and address matcher

This block is the output and addressing front end of a parallel instrument bus interface in the IEEE-488 style. It watches the data lines while the attention line (ATN) is asserted. When data lines DIO2 to DIO5 equal the configured device address, it raises a registered "addressed" qualifier for the control sequencer. A talk-always input sets the talk qualifier without any address match.

On the output side, each character placed on the bus is built from two sources. The upper bits, DIO5 to DIO7, always come from a registered sequencer microword. The low nibble, DIO1 to DIO4, comes either from a constant in the same microword or from the live 4-bit digit bus of the instrument. A select bit in the microword makes that choice. Displayed digits use the instrument nibble. Punctuation, exponent letters and line control characters come wholly from the sequencer.

ATN takes priority over the drivers. While ATN is asserted, every data-line enable and the DAV enable are low. While the sequencer's DAC-hold flag is set, ATN also forces DAC false combinationally. All lines are active-high inside the block, and polarity conversion to the electrical bus happens outside it.

Top module: `bus_talker_front`

## Requirements
- R1: After reset, addr_q_o is 0, dio_o is 8'h00, and the DAC-hold flag is set. With ATN low, dio_oe_o is 8'h7F.
- R2: On a rising clock edge with atn_i high, addr_q_o takes the result of comparing dio_in_i[4:1] (DIO2..DIO5) with addr_cfg_i[3:0], where DIO2 maps to bit 0. The result is 1 on equality. Bits dio_in_i[0] and dio_in_i[7:5] have no effect on the result.
- R3: While atn_i is low, addr_q_o holds its value.
- R4: talk_o equals addr_q_o OR talk_always_i, combinationally.
- R5: On a clock edge with seq_load_i high, dio_o[6:4] takes seq_hi_i.
- R6: When the loaded select bit is 1, dio_o[3:0] follows digit_i combinationally. When the select bit is 0, dio_o[3:0] is the loaded seq_lo_i, and changes on digit_i have no effect.
- R7: When atn_i is high, dio_oe_o[6:0] is 0, dav_oe_o is 0 and dav_o is 0. When atn_i is low, dio_oe_o[6:0] is all ones, dav_oe_o is 1 and dav_o follows seq_dav_i.
- R8: dio_o[7] and dio_oe_o[7] are always 0.
- R9: While the DAC-hold flag is set, dac_o is 0 in the same cycle that atn_i is high. While the flag is clear, dac_o follows seq_dac_i regardless of ATN. The flag is loaded from seq_dac_hold_i on a clock edge with seq_load_i high.
- R10: While seq_load_i is low, the registered character bits and the DAC-hold flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| atn_i | input | 1 | Attention line, active-high |
| dio_in_i | input | 8 | Received data lines; bit 0 is DIO1 |
| addr_cfg_i | input | 4 | Configured device address |
| talk_always_i | input | 1 | Forces the talk qualifier |
| seq_load_i | input | 1 | Loads the sequencer microword fields |
| seq_hi_i | input | 3 | Character bits for DIO5..DIO7 |
| seq_lo_i | input | 4 | Constant low nibble for DIO1..DIO4 |
| seq_use_digit_i | input | 1 | 1 = low nibble from instrument digit |
| seq_dac_hold_i | input | 1 | DAC-hold flag value to load |
| seq_dav_i | input | 1 | DAV value requested by the sequencer |
| seq_dac_i | input | 1 | DAC value requested by the sequencer |
| digit_i | input | 4 | Live instrument digit bus |
| dio_o | output | 8 | Data line drive values |
| dio_oe_o | output | 8 | Per-line driver enables |
| dav_o | output | 1 | DAV drive value |
| dav_oe_o | output | 1 | DAV driver enable |
| dac_o | output | 1 | DAC line value |
| addr_q_o | output | 1 | Registered address-match qualifier |
| talk_o | output | 1 | Talk qualifier |

## Verification
The address matcher is driven with data patterns that match, that differ in one compared bit, and that differ only in the uncompared bits DIO1 and DIO6..DIO8. These patterns separate a correct field selection from a shifted or over-wide one. ATN-low cycles carry matching and mismatching data to show that the qualifier holds, and talk-always is set while the address mismatches. Characters are loaded in both source modes, and the digit bus changes between clock edges, which shows whether the nibble is latched or live. The DAC line is checked with ATN rising under a set and a cleared hold flag.

// File: rtl/talker_pkg.sv
// Package: shared widths and the sequencer microword type for the
// bus talker front end. Assumes DIO1 is bit 0 of every data-line vector.
package talker_pkg;
    localparam int DIO_W  = 8;   // data lines on the bus
    localparam int NIB_W  = 4;   // low nibble, DIO1..DIO4
    localparam int HI_W   = 3;   // sequencer-only bits, DIO5..DIO7
    localparam int ADDR_W = 4;   // compared lines DIO2..DIO5
    localparam int ADDR_LSB = 1; // DIO2 position
    localparam int DRIVEN_W = NIB_W + HI_W;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [NIB_W-1:0] lo;
        logic             use_digit;
        logic             dac_hold;
    } char_word_t;
endpackage

// File: rtl/addr_match.sv
// Module: compares the address field of the data lines with the configured
// address while ATN is high and registers the result. Assumes active-high
// lines and a synchronous active-low reset.
module addr_match
    import talker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              atn_i,
    input  logic [DIO_W-1:0]  dio_in_i,
    input  logic [ADDR_W-1:0] addr_cfg_i,
    input  logic              talk_always_i,
    output logic              addr_q_o,
    output logic              talk_o
);
    logic [ADDR_W-1:0] field_w;
    logic              hit_w;

    // Extract the compared field and compare it with the setting.
    always_comb begin
        field_w = dio_in_i[ADDR_LSB +: ADDR_W];
        hit_w   = (field_w == addr_cfg_i);
    end

    // Register the match only during ATN; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q_o <= 1'b0;
        else if (atn_i)
            addr_q_o <= hit_w;
    end

    // The talk qualifier is the match or the talk-always setting.
    always_comb talk_o = addr_q_o | talk_always_i;
endmodule

// File: rtl/char_assemble.sv
// Module: holds the sequencer character fields and builds the data-line
// value. The low nibble is either the stored constant or the live digit
// bus. Bits above DRIVEN_W are tied low. Synchronous active-low reset.
module char_assemble
    import talker_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  char_word_t       word_i,
    input  logic [NIB_W-1:0] digit_i,
    output logic [DIO_W-1:0] data_o,
    output logic             dac_hold_o
);
    char_word_t word_q;

    // Capture the microword fields on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '{hi: '0, lo: '0, use_digit: 1'b0, dac_hold: 1'b1};
        end else if (load_i) begin
            word_q <= word_i;
        end
    end

    // Select the low-nibble source and place each field on its lines.
    always_comb begin
        data_o = '0;
        data_o[NIB_W-1:0] = word_q.use_digit ? digit_i : word_q.lo;
        data_o[NIB_W +: HI_W] = word_q.hi;
        dac_hold_o = word_q.dac_hold;
    end
endmodule

// File: rtl/bus_gate.sv
// Module: applies ATN priority to the driver enables, DAV and DAC.
// It is purely combinational and assumes active-high ATN.
module bus_gate
    import talker_pkg::*;
(
    input  logic             atn_i,
    input  logic [DIO_W-1:0] data_i,
    input  logic             seq_dav_i,
    input  logic             seq_dac_i,
    input  logic             dac_hold_i,
    output logic [DIO_W-1:0] dio_o,
    output logic [DIO_W-1:0] dio_oe_o,
    output logic             dav_o,
    output logic             dav_oe_o,
    output logic             dac_o
);
    // Per-line enable: driven lines follow ATN, the rest stay off.
    for (genvar g = 0; g < DIO_W; g++) begin : g_oe
        if (g < DRIVEN_W) begin : g_drv
            assign dio_oe_o[g] = ~atn_i;
            assign dio_o[g]    = data_i[g];
        end else begin : g_off
            assign dio_oe_o[g] = 1'b0;
            assign dio_o[g]    = 1'b0;
        end
    end

    // DAV is silenced by ATN; DAC is pulled false while the hold flag is set.
    always_comb begin
        dav_oe_o = ~atn_i;
        dav_o    = seq_dav_i & ~atn_i;
        dac_o    = seq_dac_i & ~(atn_i & dac_hold_i);
    end
endmodule

// File: rtl/bus_talker_front.sv
// Top: bus talker output and address matcher. It ties the address matcher,
// the character assembler and the ATN gate together. All lines are
// active-high; bus polarity conversion is done outside the block.
module bus_talker_front
    import talker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              atn_i,
    input  logic [DIO_W-1:0]  dio_in_i,
    input  logic [ADDR_W-1:0] addr_cfg_i,
    input  logic              talk_always_i,
    input  logic              seq_load_i,
    input  logic [HI_W-1:0]   seq_hi_i,
    input  logic [NIB_W-1:0]  seq_lo_i,
    input  logic              seq_use_digit_i,
    input  logic              seq_dac_hold_i,
    input  logic              seq_dav_i,
    input  logic              seq_dac_i,
    input  logic [NIB_W-1:0]  digit_i,
    output logic [DIO_W-1:0]  dio_o,
    output logic [DIO_W-1:0]  dio_oe_o,
    output logic              dav_o,
    output logic              dav_oe_o,
    output logic              dac_o,
    output logic              addr_q_o,
    output logic              talk_o
);
    char_word_t       word_w;
    logic [DIO_W-1:0] char_w;
    logic             hold_w;

    // Gather the flat sequencer inputs into one microword.
    always_comb begin
        word_w.hi        = seq_hi_i;
        word_w.lo        = seq_lo_i;
        word_w.use_digit = seq_use_digit_i;
        word_w.dac_hold  = seq_dac_hold_i;
    end

    addr_match u_match (
        .clk(clk), .rst_n(rst_n), .atn_i(atn_i), .dio_in_i(dio_in_i),
        .addr_cfg_i(addr_cfg_i), .talk_always_i(talk_always_i),
        .addr_q_o(addr_q_o), .talk_o(talk_o)
    );

    char_assemble u_char (
        .clk(clk), .rst_n(rst_n), .load_i(seq_load_i), .word_i(word_w),
        .digit_i(digit_i), .data_o(char_w), .dac_hold_o(hold_w)
    );

    bus_gate u_gate (
        .atn_i(atn_i), .data_i(char_w), .seq_dav_i(seq_dav_i),
        .seq_dac_i(seq_dac_i), .dac_hold_i(hold_w), .dio_o(dio_o),
        .dio_oe_o(dio_oe_o), .dav_o(dav_o), .dav_oe_o(dav_oe_o),
        .dac_o(dac_o)
    );
endmodule

// File: rtl/bus_talker_front_chk.sv
// Checker: properties of the talker front end, bound to the top module.
module bus_talker_front_chk
    import talker_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              atn_i,
    input logic [DIO_W-1:0]  dio_in_i,
    input logic [ADDR_W-1:0] addr_cfg_i,
    input logic              seq_load_i,
    input logic [HI_W-1:0]   seq_hi_i,
    input logic              seq_dac_i,
    input logic [DIO_W-1:0]  dio_o,
    input logic [DIO_W-1:0]  dio_oe_o,
    input logic              dav_oe_o,
    input logic              dac_o,
    input logic              addr_q_o,
    input logic              hold_w
);
    a_r2_match_registered: assert property (@(posedge clk) disable iff (!rst_n)
        atn_i |=> addr_q_o == ($past(dio_in_i[ADDR_LSB +: ADDR_W]) == $past(addr_cfg_i)));

    a_r3_hold_without_atn: assert property (@(posedge clk) disable iff (!rst_n)
        !atn_i |=> $stable(addr_q_o));

    a_r5_hi_bits_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        seq_load_i |=> dio_o[NIB_W +: HI_W] == $past(seq_hi_i));

    a_r10_hi_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_load_i |=> $stable(dio_o[NIB_W +: HI_W]));

    a_r7_atn_disables: assert property (@(posedge clk) disable iff (!rst_n)
        atn_i |-> (dio_oe_o == '0 && !dav_oe_o));

    a_r8_top_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dio_oe_o[DIO_W-1] && !dio_o[DIO_W-1]);

    a_r9_dac_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (atn_i && hold_w) |-> !dac_o);

    a_r9_dac_released: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_w |-> dac_o == seq_dac_i);
endmodule

bind bus_talker_front bus_talker_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .atn_i(atn_i), .dio_in_i(dio_in_i),
    .addr_cfg_i(addr_cfg_i), .seq_load_i(seq_load_i), .seq_hi_i(seq_hi_i),
    .seq_dac_i(seq_dac_i), .dio_o(dio_o), .dio_oe_o(dio_oe_o),
    .dav_oe_o(dav_oe_o), .dac_o(dac_o), .addr_q_o(addr_q_o), .hold_w(hold_w)
);

// File: tb/bus_talker_front_tb_top.sv
module bus_talker_front_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       atn_i = 1'b0;
    logic [7:0] dio_in_i = '0;
    logic [3:0] addr_cfg_i = '0;
    logic       talk_always_i = 1'b0;
    logic       seq_load_i = 1'b0;
    logic [2:0] seq_hi_i = '0;
    logic [3:0] seq_lo_i = '0;
    logic       seq_use_digit_i = 1'b0;
    logic       seq_dac_hold_i = 1'b1;
    logic       seq_dav_i = 1'b0;
    logic       seq_dac_i = 1'b0;
    logic [3:0] digit_i = '0;
    logic [7:0] dio_o, dio_oe_o;
    logic       dav_o, dav_oe_o, dac_o, addr_q_o, talk_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_talker_front dut_i (.*);

    // Vector: {atn, dio_in[7:0], cfg[3:0], talk_always, exp_addr, exp_talk}
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 8'h14, 4'hA, 1'b0, 1'b1, 1'b1},  // bits 4:1 = A, match
        {1'b1, 8'h14, 4'hB, 1'b0, 1'b0, 1'b0},  // one bit differs
        {1'b0, 8'h16, 4'hB, 1'b0, 1'b0, 1'b0},  // would match, ATN low: hold
        {1'b1, 8'h16, 4'hB, 1'b0, 1'b1, 1'b1},  // match
        {1'b0, 8'h00, 4'h0, 1'b0, 1'b1, 1'b1},  // hold at 1
        {1'b1, 8'hE1, 4'h0, 1'b0, 1'b1, 1'b1},  // uncompared bits ignored
        {1'b1, 8'hE1, 4'h1, 1'b1, 1'b0, 1'b1},  // mismatch, talk-always
        {1'b1, 8'h1E, 4'hF, 1'b0, 1'b1, 1'b1}   // all ones field
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_char(input logic [2:0] hi, input logic [3:0] lo,
                             input logic use_d, input logic hold);
        @(negedge clk);
        seq_hi_i = hi; seq_lo_i = lo; seq_use_digit_i = use_d;
        seq_dac_hold_i = hold; seq_load_i = 1'b1;
        @(negedge clk);
        seq_load_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 addr", {7'd0, addr_q_o}, 8'h00);
        check("R1 dio", dio_o, 8'h00);
        check("R1 oe", dio_oe_o, 8'h7F);
        seq_dac_i = 1'b1; atn_i = 1'b1; #1;
        check("R1 R9 hold flag set", {7'd0, dac_o}, 8'h00);
        atn_i = 1'b0; seq_dac_i = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {atn_i, dio_in_i, addr_cfg_i, talk_always_i} = VEC[i][15:2];
            @(posedge clk); #2;
            check($sformatf("R2 R3 addr vec%0d", i), {7'd0, addr_q_o}, {7'd0, VEC[i][1]});
            check($sformatf("R4 talk vec%0d", i), {7'd0, talk_o}, {7'd0, VEC[i][0]});
        end
        @(negedge clk); atn_i = 1'b0; talk_always_i = 1'b0;

        // R5 / R6 constant character 0x45
        load_char(3'b100, 4'h5, 1'b0, 1'b1);
        check("R5 R6 const char", dio_o, 8'h45);
        digit_i = 4'h9; #1;
        check("R6 digit ignored", dio_o, 8'h45);
        // R6 live digit
        digit_i = 4'h7;
        load_char(3'b011, 4'h0, 1'b1, 1'b1);
        check("R6 digit char", dio_o, 8'h37);
        digit_i = 4'h2; #1;
        check("R6 live digit", dio_o, 8'h32);
        // R10 hold without load
        seq_hi_i = 3'b111; seq_use_digit_i = 1'b0; seq_lo_i = 4'hF;
        @(negedge clk); @(negedge clk);
        check("R10 hold", dio_o, 8'h32);
        // R7 / R8 ATN gating
        seq_dav_i = 1'b1; #1;
        check("R7 dav passes", {6'd0, dav_oe_o, dav_o}, 8'h03);
        atn_i = 1'b1; #1;
        check("R7 R8 oe off", dio_oe_o, 8'h00);
        check("R7 dav off", {6'd0, dav_oe_o, dav_o}, 8'h00);
        check("R8 top line", {7'd0, dio_o[7]}, 8'h00);
        // R9 DAC
        atn_i = 1'b0; seq_dac_i = 1'b1; #1;
        check("R9 dac normal", {7'd0, dac_o}, 8'h01);
        atn_i = 1'b1; #1;
        check("R9 dac forced", {7'd0, dac_o}, 8'h00);
        load_char(3'b011, 4'h0, 1'b1, 1'b0);
        check("R9 dac released", {7'd0, dac_o}, 8'h01);
        seq_dac_i = 1'b0; #1;
        check("R9 dac follows", {7'd0, dac_o}, 8'h00);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule